// File: doc/BRIEF.md
# Serial DAC Command Frame Transmitter

This block is a serial-peripheral master that forwards conversion updates to an external 12-bit digital-to-analog converter. Each accepted update carries a 12-bit code, a settling-speed choice and a shutdown request. The block turns these into one 16-bit command word and shifts it out under an active-low select line.

The serial clock idles high. The block moves the data line only when the clock rises, so the converter samples each bit on the falling edge. The most significant bit goes first. The serial clock is the system clock divided by an even parameter. The default of 8 turns an 80 MHz system clock into a 10 MHz serial clock.

Upstream logic offers updates on a valid/ready pair. `upd_ready` is low for the whole time a frame is on the wire. An update held valid at the end of a frame is taken on the next clock edge.

Top module: `dacspi_tx`

## Requirements
- R1: After reset, `dac_cs_n` is 1, `dac_sclk` is 1, `dac_mosi` is 0 and `upd_ready` is 1. While `dac_cs_n` is high, `dac_sclk` stays 1 and `dac_mosi` stays 0.
- R2: Frame bit 15 (the first bit sent) and frame bit 12 (the fourth bit sent) are always sent as 0.
- R3: Frame bit 14 (the second bit sent) equals `upd_fast`: 1 selects fast settling, 0 selects slow settling.
- R4: Frame bit 13 (the third bit sent) equals `upd_pdown`: 1 requests shutdown, 0 requests normal operation.
- R5: Frame bits 11..0 carry `upd_code` most significant bit first. These are the 5th to 16th bits sampled on falling edges of `dac_sclk`.
- R6: Each accepted update (`upd_valid` and `upd_ready` high at a rising `clk` edge) produces exactly one frame, with exactly 16 falling edges of `dac_sclk` while `dac_cs_n` is low.
- R7: `dac_mosi` changes only in a cycle where `dac_sclk` rises or is high. It is stable in every cycle where `dac_sclk` is low.
- R8: `dac_cs_n` falls on the edge that accepts an update, with `dac_sclk` high. The first falling edge of `dac_sclk` comes CLK_DIV/2 system cycles later.
- R9: `dac_cs_n` returns high CLK_DIV/2 cycles after the 16th falling edge, together with the final rise of `dac_sclk`. It stays low for 16*CLK_DIV cycles in total, and `upd_ready` is 0 throughout that time.
- R10: An `upd_valid` pulse that ends while `upd_ready` is 0 is ignored. It changes neither the frame in flight nor starts another frame.
- R11: If `upd_valid` is held high when a frame ends, the next update is accepted one cycle after `dac_cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Update offered |
| upd_ready | output | 1 | Transmitter idle, update can be taken |
| upd_code | input | 12 | Conversion code |
| upd_fast | input | 1 | 1 = fast settling, 0 = slow settling |
| upd_pdown | input | 1 | 1 = shut the converter down |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_cs_n | output | 1 | Active-low frame select |
| dac_mosi | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with CLK_DIV set to 4, so each half period of the serial clock is two system cycles. This keeps frames short enough to run many of them. The lead-in and tail delays of the select line and the total select-low time can then be counted exactly against the half period. The bench exercises the all-zeros and all-ones codes, both settings of the control bits, an update offered mid-frame, and updates held valid back to back.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;

    localparam int FRAME_W = 16;
    localparam int CODE_W  = 12;

    // Command word, most significant field first (wire order).
    typedef struct packed {
        logic              rsv_hi;
        logic              fast;
        logic              pdown;
        logic              rsv_lo;
        logic [CODE_W-1:0] code;
    } dac_frame_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } shift_state_e;

    function automatic dac_frame_t pack_frame(
        input logic [CODE_W-1:0] code,
        input logic              fast,
        input logic              pdown
    );
        dac_frame_t f;
        f.rsv_hi = 1'b0;
        f.fast   = fast;
        f.pdown  = pdown;
        f.rsv_lo = 1'b0;
        f.code   = code;
        return f;
    endfunction

endpackage

// File: rtl/dacspi_halftick.sv
module dacspi_halftick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (HALF == 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            localparam int CNT_W = $clog2(HALF);
            logic [CNT_W-1:0] cnt;

            assign tick = run && (cnt == CNT_W'(HALF - 1));

            always_ff @(posedge clk) begin
                if (rst || !run || tick) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dacspi_framer.sv
module dacspi_framer
    import dacspi_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    input  logic               fast,
    input  logic               pdown,
    output logic [FRAME_W-1:0] frame
);
    dac_frame_t f;

    always_comb begin
        f     = pack_frame(code, fast, pdown);
        frame = f;
    end
endmodule

// File: rtl/dacspi_shifter.sv
module dacspi_shifter
    import dacspi_pkg::*;
#(
    parameter int BITS = FRAME_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] frame_in,
    input  logic            tick,
    output logic            busy,
    output logic            sclk,
    output logic            cs_n,
    output logic            mosi
);
    localparam int LEFT_W = $clog2(BITS + 1);

    shift_state_e      st;
    logic [BITS-1:0]   sh;
    logic [LEFT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            sclk <= 1'b1;
            cs_n <= 1'b1;
            sh   <= '0;
            left <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (load) begin
                        sh   <= frame_in;
                        cs_n <= 1'b0;
                        sclk <= 1'b1;
                        left <= LEFT_W'(BITS);
                        st   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (sclk) begin
                            // falling edge: receiver samples sh MSB
                            sclk <= 1'b0;
                            left <= left - 1'b1;
                        end else begin
                            sclk <= 1'b1;
                            if (left == '0) begin
                                cs_n <= 1'b1;
                                sh   <= '0;
                                st   <= ST_IDLE;
                            end else begin
                                sh <= {sh[BITS-2:0], 1'b0};
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st == ST_SHIFT);
    assign mosi = sh[BITS-1];
endmodule

// File: rtl/dacspi_tx.sv
module dacspi_tx
    import dacspi_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    output logic              upd_ready,
    input  logic [CODE_W-1:0] upd_code,
    input  logic              upd_fast,
    input  logic              upd_pdown,
    output logic              dac_sclk,
    output logic              dac_cs_n,
    output logic              dac_mosi
);
    localparam int HALF = CLK_DIV / 2;

    logic [FRAME_W-1:0] frame;
    logic               busy;
    logic               tick;
    logic               load;

    assign upd_ready = !busy;
    assign load      = upd_valid && !busy;

    dacspi_framer u_framer (
        .code  (upd_code),
        .fast  (upd_fast),
        .pdown (upd_pdown),
        .frame (frame)
    );

    dacspi_halftick #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    dacspi_shifter #(.BITS(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .frame_in (frame),
        .tick     (tick),
        .busy     (busy),
        .sclk     (dac_sclk),
        .cs_n     (dac_cs_n),
        .mosi     (dac_mosi)
    );
endmodule

// File: rtl/dacspi_tx_chk.sv
module dacspi_tx_chk #(
    parameter int NBITS = 16
) (
    input logic clk,
    input logic rst,
    input logic upd_ready,
    input logic dac_sclk,
    input logic dac_cs_n,
    input logic dac_mosi
);
    logic       sclk_d;
    logic [5:0] falls;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b1;
            falls  <= '0;
        end else begin
            sclk_d <= dac_sclk;
            if (dac_cs_n) begin
                falls <= '0;
            end else if (sclk_d && !dac_sclk) begin
                falls <= falls + 1'b1;
            end
        end
    end

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        dac_cs_n |-> (dac_sclk && !dac_mosi)); // R1

    AST_MOSI_HELD_LOW: assert property (@(posedge clk) disable iff (rst)
        (!dac_sclk && !$past(rst)) |-> $stable(dac_mosi)); // R7

    AST_SELECT_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_cs_n) |-> dac_sclk); // R8

    AST_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_cs_n) |-> $rose(dac_sclk)); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !dac_cs_n |-> !upd_ready); // R9

    AST_FALL_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_cs_n) |-> (falls == 6'(NBITS))); // R6
endmodule

bind dacspi_tx dacspi_tx_chk #(.NBITS(16)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .upd_ready (upd_ready),
    .dac_sclk  (dac_sclk),
    .dac_cs_n  (dac_cs_n),
    .dac_mosi  (dac_mosi)
);

// File: tb/tb_dacspi_tx.sv
`timescale 1ns/1ps
module tb_dacspi_tx;
    localparam int CLK_DIV = 4;
    localparam int HALF    = CLK_DIV / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_valid = 1'b0;
    logic        upd_ready;
    logic [11:0] upd_code = '0;
    logic        upd_fast = 1'b0;
    logic        upd_pdown = 1'b0;
    logic        dac_sclk, dac_cs_n, dac_mosi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dacspi_tx #(.CLK_DIV(CLK_DIV)) dut (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_ready(upd_ready),
        .upd_code(upd_code), .upd_fast(upd_fast), .upd_pdown(upd_pdown),
        .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n), .dac_mosi(dac_mosi)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [11:0] c, input logic f, input logic p);
        return {1'b0, f, p, 1'b0, c};
    endfunction

    // Called at the negedge right after the accepting posedge.
    task automatic capture(output logic [15:0] bits, output int nfall,
                           output int first_fall, output int cs_len, output bit rdy_seen);
        logic prev = 1'b1;
        bits = '0; nfall = 0; first_fall = -1; cs_len = 0; rdy_seen = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (dac_cs_n) break;
            cs_len++;
            if (upd_ready) rdy_seen = 1'b1;
            if (prev && !dac_sclk) begin
                if (nfall == 0) first_fall = cs_len;
                if (nfall < 16) bits[15 - nfall] = dac_mosi;
                nfall++;
            end
            prev = dac_sclk;
            @(negedge clk);
        end
    endtask

    task automatic offer(input logic [11:0] c, input logic f, input logic p);
        @(negedge clk);
        upd_code = c; upd_fast = f; upd_pdown = p; upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset;
        check(dac_cs_n === 1'b1, "R1 cs_n", dac_cs_n, 1);
        check(dac_sclk === 1'b1, "R1 sclk", dac_sclk, 1);
        check(dac_mosi === 1'b0, "R1 mosi", dac_mosi, 0);
        check(upd_ready === 1'b1, "R1 ready", upd_ready, 1);
    endtask

    task automatic t_frame(input logic [11:0] c, input logic f, input logic p);
        logic [15:0] bits, exp;
        int nf, ff, len;
        bit rdy;
        exp = model(c, f, p);
        offer(c, f, p);
        capture(bits, nf, ff, len, rdy);
        check(bits[15] == 1'b0 && bits[12] == 1'b0, "R2 reserved", bits, exp);
        check(bits[14] == f, "R3 speed bit", bits[14], f);
        check(bits[13] == p, "R4 shutdown bit", bits[13], p);
        check(bits[11:0] == c, "R5 code", bits[11:0], c);
        check(nf == 16, "R6 falling edges", nf, 16);
        check(ff == HALF + 1, "R8 lead-in", ff, HALF + 1);
        check(len == 16 * CLK_DIV, "R9 select length", len, 16 * CLK_DIV);
        check(!rdy, "R9 ready low in frame", rdy, 0);
        check(dac_sclk && !dac_mosi && upd_ready, "R1 idle after frame",
              {dac_sclk, dac_mosi, upd_ready}, 3'b101);
    endtask

    task automatic t_busy_ignored;
        logic [15:0] bits, exp;
        int nf, ff, len, extra;
        bit rdy;
        exp = model(12'h5A3, 1'b1, 1'b0);
        offer(12'h5A3, 1'b1, 1'b0);
        fork
            capture(bits, nf, ff, len, rdy);
            begin
                repeat (10) @(negedge clk);
                upd_code = 12'hFFF; upd_fast = 1'b0; upd_pdown = 1'b1; upd_valid = 1'b1;
                repeat (3) @(negedge clk);
                upd_valid = 1'b0;
            end
        join
        check(bits == exp, "R10 frame unchanged", bits, exp);
        extra = 0;
        for (int i = 0; i < 3 * CLK_DIV; i++) begin
            @(negedge clk);
            if (!dac_cs_n) extra++;
        end
        check(extra == 0, "R10 no second frame", extra, 0);
    endtask

    task automatic t_back_to_back;
        logic [15:0] b1, b2;
        int nf, ff, len;
        bit rdy;
        @(negedge clk);
        upd_code = 12'h123; upd_fast = 1'b0; upd_pdown = 1'b0; upd_valid = 1'b1;
        @(negedge clk);
        upd_code = 12'hABC; upd_fast = 1'b1; upd_pdown = 1'b1;
        capture(b1, nf, ff, len, rdy);
        check(b1 == model(12'h123, 1'b0, 1'b0), "R6 first of pair", b1, model(12'h123, 1'b0, 1'b0));
        check(upd_ready == 1'b1 && dac_cs_n, "R11 gap cycle", {upd_ready, dac_cs_n}, 2'b11);
        @(negedge clk);
        upd_valid = 1'b0;
        check(dac_cs_n == 1'b0, "R11 next accepted", dac_cs_n, 0);
        capture(b2, nf, ff, len, rdy);
        check(b2 == model(12'hABC, 1'b1, 1'b1), "R11 second of pair", b2, model(12'hABC, 1'b1, 1'b1));
        check(nf == 16, "R6 second count", nf, 16);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_frame(12'h000, 1'b0, 1'b0);
        t_frame(12'hFFF, 1'b1, 1'b1);
        t_frame(12'h801, 1'b1, 1'b0);
        t_frame(12'h3E4, 1'b0, 1'b1);
        t_busy_ignored();
        t_back_to_back();
        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule